// File: doc/BRIEF.md
# Write-Enable Latch and Block Protection Guard

This block gates every write that a serial nonvolatile memory front end wants to perform. It keeps a write-enable latch and a two-bit block-protect field, and it combines them with the active-low write-protect pin to decide two things:

- whether a status-register write may commit;
- whether a byte at a given array address may be written.

The command decoder drives one-cycle strobes into it. These are write-enable, write-disable, status-write with its data byte, and write-termination, which the decoder raises when chip select rises to end a write command. The decoder also presents the current, auto-incremented byte address. The memory datapath reads the two permit outputs combinationally and commits a byte only when its permit is high. A burst that walks into a protected region therefore stops committing bytes at the boundary.

A status byte is presented for read-back. The block-protect field models nonvolatile storage: a soft reset clears the write-enable latch but leaves the block-protect field alone, and only the power-on reset clears both. Each reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `wep_guard`

## Requirements
- R1: The status byte reads bit 3 = protect-high bit, bit 2 = protect-low bit, bit 1 = write-enable latch, and bits 7..4 and bit 0 always 0.
- R2: After power-on reset the status byte is 0x00 and both permit outputs are low.
- R3: A write-enable strobe sets the latch; status bit 1 reads 1 from the following cycle.
- R4: A write-disable strobe or a write-termination strobe clears the latch in the following cycle, and a clear wins over a set strobe in the same cycle.
- R5: A permitted status write loads the protect field from data bits 3:2; data bits 7..4 and 1..0 are ignored, and in particular data bit 1 does not change the latch.
- R6: A status write made while the latch is 0 or the protect pin is low leaves the protect field unchanged.
- R7: With a write otherwise allowed, field 00 protects nothing, 01 protects 0x180–0x1FF, 10 protects 0x100–0x1FF and 11 protects 0x000–0x1FF (for a 9-bit address).
- R8: While the latch is 0, both permit outputs are low.
- R9: While the protect pin is low, both permit outputs are low.
- R10: While the latch is 1 and the protect pin is high, the status permit is high and the memory permit is high exactly for unprotected addresses, following the address in the same cycle.
- R11: A soft reset clears the latch and leaves the protect field unchanged.
- R12: A permitted status write and a write-termination in the same cycle both take effect: the protect field takes the new value and the latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears latch and protect field |
| rst_n | input | 1 | Soft reset, active low; clears the latch only |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe, qualified by the status permit |
| sr_wdata | input | 8 | Status-write data byte |
| wr_term | input | 1 | End of a write command (chip select rising) |
| cand_addr | input | ADDR_W | Byte address of the candidate memory write |
| status_q | output | 8 | Status byte for read-back |
| mem_wr_ok | output | 1 | Memory byte write permitted at cand_addr |
| sr_wr_ok | output | 1 | Status write permitted |

## Verification
A status write and the write-termination that closes it can land in the same cycle. The permit for that status write must be judged on the latch value from before that cycle, while the latch itself clears. The bench raises both strobes together and then expects the new protect field with bit 1 already zero (R12). It also raises set and clear strobes together and expects the latch to be zero. Every protect setting is then swept against both latch states, both pin levels and all 512 addresses, with the permit computed from address arithmetic.

// File: rtl/wep_pkg.sv
package wep_pkg;

  // Block-protect field encodings; the order is decoded by the region logic.
  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_mode_e;

  localparam int STAT_W  = 8;
  localparam int BP_W    = 2;
  localparam int POS_WEL = 1;
  localparam int POS_BP  = 2;   // low bit of the protect field in the status byte

endpackage

// File: rtl/wep_rst_sync.sv
module wep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wep_latch.sv
module wep_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);

  logic wel_q;
  logic wel_d;
  logic wel_en;

  always_comb begin
    wel_en = set_i | clr_i;
    wel_d  = wel_q;
    if (clr_i) begin
      wel_d = 1'b0;
    end else if (set_i) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (wel_en) begin
      wel_q <= wel_d;
    end
  end

  assign wel_o = wel_q;

  // R3: a lone set strobe leaves the latch set
  a_r3_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> wel_o);

  // R4: a clear strobe wins, even against a set
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !wel_o);

  // R4: with no strobe the latch holds
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(wel_o));

endmodule

// File: rtl/wep_bp_reg.sv
module wep_bp_reg #(
  parameter int BP_W = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            load_i,
  input  logic [BP_W-1:0] data_i,
  output logic [BP_W-1:0] bp_o
);

  logic [BP_W-1:0] bp_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bp_q <= '0;
    end else if (load_i) begin
      bp_q <= data_i;
    end
  end

  assign bp_o = bp_q;

  // R5: a permitted load takes the data
  a_r5_bp_load: assert property (@(posedge clk) disable iff (!por_n)
    load_i |=> (bp_o == $past(data_i)));

  // R6: without a load the field is stable
  a_r6_bp_hold: assert property (@(posedge clk) disable iff (!por_n)
    !load_i |=> $stable(bp_o));

endmodule

// File: rtl/wep_region.sv
module wep_region
  import wep_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  bp_mode_e          bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);

  localparam int TOP = ADDR_W - 1;

  logic in_upper_half;
  logic in_upper_qtr;

  assign in_upper_half = addr_i[TOP];
  assign in_upper_qtr  = &addr_i[TOP -: 2];

  always_comb begin
    unique case (bp_i)
      BP_NONE: prot_o = 1'b0;
      BP_QTR:  prot_o = in_upper_qtr;
      BP_HALF: prot_o = in_upper_half;
      BP_ALL:  prot_o = 1'b1;
      default: prot_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/wep_guard.sv
module wep_guard
  import wep_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        sr_wdata,
  input  logic              wr_term,
  input  logic [ADDR_W-1:0] cand_addr,
  output logic [7:0]        status_q,
  output logic              mem_wr_ok,
  output logic              sr_wr_ok
);

  logic            por_sync_n;
  logic            soft_sync_n;
  logic            soft_arst_n;
  logic            wel;
  logic            latch_clr;
  logic            sr_commit;
  logic [BP_W-1:0] bp;
  logic            prot;
  logic            unused_wdata;

  assign soft_arst_n = rst_n & por_n;

  wep_rst_sync #(.STAGES(2)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_sync_n)
  );

  wep_rst_sync #(.STAGES(2)) u_soft_sync (
    .clk    (clk),
    .arst_n (soft_arst_n),
    .srst_n (soft_sync_n)
  );

  // Permission for status writes uses the latch value from before this edge.
  assign sr_wr_ok  = wel & wp_n;
  assign sr_commit = cmd_wrsr & sr_wr_ok;
  assign latch_clr = cmd_wrdi | wr_term;

  wep_latch u_latch (
    .clk   (clk),
    .rst_n (soft_sync_n),
    .set_i (cmd_wren),
    .clr_i (latch_clr),
    .wel_o (wel)
  );

  wep_bp_reg #(.BP_W(BP_W)) u_bp (
    .clk    (clk),
    .por_n  (por_sync_n),
    .load_i (sr_commit),
    .data_i (sr_wdata[POS_BP +: BP_W]),
    .bp_o   (bp)
  );

  assign unused_wdata = ^{sr_wdata[7:POS_BP+BP_W], sr_wdata[POS_BP-1:0]};

  wep_region #(.ADDR_W(ADDR_W)) u_region (
    .bp_i   (bp_mode_e'(bp)),
    .addr_i (cand_addr),
    .prot_o (prot)
  );

  assign mem_wr_ok = wel & wp_n & ~prot;

  always_comb begin
    status_q                   = '0;
    status_q[POS_WEL]          = wel;
    status_q[POS_BP +: BP_W]   = bp;
  end

  // R8: a clear latch blocks everything
  a_r8_wel_blocks: assert property (@(posedge clk) disable iff (!soft_sync_n)
    !status_q[POS_WEL] |-> (!mem_wr_ok && !sr_wr_ok));

  // R9: the pin overrides everything
  a_r9_pin_blocks: assert property (@(posedge clk) disable iff (!soft_sync_n)
    !wp_n |-> (!mem_wr_ok && !sr_wr_ok));

  // R7: full-array protection never permits a memory write
  a_r7_all_blocks: assert property (@(posedge clk) disable iff (!soft_sync_n)
    (status_q[POS_BP +: BP_W] == 2'b11) |-> !mem_wr_ok);

  // R12: a termination clears the latch even when a status write commits with it
  a_r12_term_with_wrsr: assert property (@(posedge clk) disable iff (!soft_sync_n)
    (sr_commit && wr_term) |=> (!status_q[POS_WEL] &&
      status_q[POS_BP +: BP_W] == $past(sr_wdata[POS_BP +: BP_W])));

endmodule

// File: tb/wep_guard_test.sv
module wep_guard_test;

  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          por_n, rst_n, wp_n;
  logic          cmd_wren, cmd_wrdi, cmd_wrsr, wr_term;
  logic [7:0]    sr_wdata;
  logic [AW-1:0] cand_addr;
  logic [7:0]    status_q;
  logic          mem_wr_ok, sr_wr_ok;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  wep_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .sr_wdata(sr_wdata), .wr_term(wr_term), .cand_addr(cand_addr),
    .status_q(status_q), .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok)
  );

  function automatic logic [7:0] stat_exp(input logic [1:0] bp, input logic wel);
    return {4'b0000, bp, wel, 1'b0};
  endfunction

  function automatic logic prot_exp(input logic [1:0] bp, input int a);
    return (bp == 2'd3) || (bp == 2'd2 && a >= 256) || (bp == 2'd1 && a >= 384);
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes just after a falling edge, clear them at the next one.
  task automatic strobe(input logic en, input logic di, input logic sr,
                        input logic tm, input logic [7:0] d);
    cmd_wren = en; cmd_wrdi = di; cmd_wrsr = sr; wr_term = tm; sr_wdata = d;
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wr_term = 0; sr_wdata = 8'h00;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0; wp_n = 1;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; wr_term = 0;
    sr_wdata = 8'h00; cand_addr = '0;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    settle();

    // R2 / R1: reset state
    chk8("R2 status after power-on", status_q, 8'h00);
    chk1("R2 mem permit after power-on", mem_wr_ok, 1'b0);
    chk1("R2 sr permit after power-on", sr_wr_ok, 1'b0);

    // R3
    strobe(1, 0, 0, 0, 8'h00);
    chk8("R3 set latch", status_q, stat_exp(2'b00, 1));
    chk1("R10 sr permit with latch set", sr_wr_ok, 1'b1);

    // R5 / R1: data 0xFF loads only bits 3:2
    strobe(0, 0, 1, 0, 8'hFF);
    chk8("R5 status write of 0xFF", status_q, stat_exp(2'b11, 1));
    strobe(0, 0, 1, 0, 8'hF1);
    chk8("R5 data bit1 ignored", status_q, stat_exp(2'b00, 1));
    strobe(0, 0, 1, 0, 8'h0C);
    // R4: termination clears
    strobe(0, 0, 0, 1, 8'h00);
    chk8("R4 termination clears latch", status_q, stat_exp(2'b11, 0));

    // R6: status write with latch clear
    strobe(0, 0, 1, 0, 8'h00);
    chk8("R6 write blocked by clear latch", status_q, stat_exp(2'b11, 0));

    // R6 / R9: status write with pin low
    strobe(1, 0, 0, 0, 8'h00);
    wp_n = 0;
    #1 chk1("R9 sr permit with pin low", sr_wr_ok, 1'b0);
    strobe(0, 0, 1, 0, 8'h00);
    chk8("R6 write blocked by pin", status_q, stat_exp(2'b11, 1));
    wp_n = 1;

    // R12: status write together with termination
    strobe(0, 0, 1, 1, 8'h04);
    chk8("R12 write and termination together", status_q, stat_exp(2'b01, 0));

    // R4: clear wins over set
    strobe(1, 1, 0, 0, 8'h00);
    chk8("R4 disable beats enable", status_q, stat_exp(2'b01, 0));
    strobe(1, 0, 0, 1, 8'h00);
    chk8("R4 termination beats enable", status_q, stat_exp(2'b01, 0));
    strobe(1, 0, 0, 0, 8'h00);
    strobe(0, 1, 0, 0, 8'h00);
    chk8("R4 disable clears latch", status_q, stat_exp(2'b01, 0));

    // R11: soft reset keeps the protect field
    strobe(1, 0, 0, 0, 8'h00);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    settle();
    chk8("R11 soft reset keeps protect field", status_q, stat_exp(2'b01, 0));

    // R2: power-on reset clears all
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    settle();
    chk8("R2 power-on clears protect field", status_q, 8'h00);

    // R7 R8 R9 R10 R1: sweep
    for (int bp = 0; bp < 4; bp++) begin
      strobe(1, 0, 0, 0, 8'h00);
      strobe(0, 0, 1, 1, 8'(bp << 2));
      for (int wel = 0; wel < 2; wel++) begin
        if (wel == 1) strobe(1, 0, 0, 0, 8'h00);
        else          strobe(0, 1, 0, 0, 8'h00);
        chk8("R1 status layout in sweep", status_q, stat_exp(2'(bp), 1'(wel)));
        for (int wp = 0; wp < 2; wp++) begin
          wp_n = 1'(wp);
          for (int a = 0; a < 512; a++) begin
            cand_addr = AW'(a);
            #1;
            chk1("R7 R8 R9 R10 memory permit", mem_wr_ok,
                 (wel == 1) && (wp == 1) && !prot_exp(2'(bp), a));
            chk1("R8 R9 R10 status permit", sr_wr_ok, (wel == 1) && (wp == 1));
          end
        end
        wp_n = 1;
        @(negedge clk);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule